// File: doc/BRIEF.md
# Serial Flash Interrupt Status and Gating Unit

This unit is the interrupt front end of a serial flash controller. It watches the fill levels of the transmit and receive FIFOs and the single-cycle event pulses of the descriptor engine. Each observed condition is caught in its own bit of a status word. A bit that has been caught cannot be acknowledged. Software quiets an event only by clearing that bit in the enable mask. A second mask, the signal-enable mask, sits between the enabled status and the single active-high, level-sensitive interrupt line.

A write port takes one register write per cycle, selected by a 2-bit code. The unit also holds the two 5-bit FIFO threshold fields. A soft reset request runs for a fixed number of cycles. During that time it empties the status word and returns the thresholds to their working value of 1. The masks are left as they are. When the reset ends, the FIFO conditions that still hold are caught again. If the masks allow it, the interrupt line then rises without any other event.

Top module: `flash_irq_ctrl`

## Requirements
- R1: Status bit positions: 0 transmit empty (tx level 0), 1 transmit full (tx level equals FIFO_DEPTH), 2 transmit threshold (tx level at or below the tx threshold), 3 receive empty, 4 receive full, 5 receive threshold (rx level at or above the rx threshold), 9 descriptor done, 10 packet complete, 11 DMA error. Bits 6 to 8 always read 0. A condition present in one cycle shows in the status word after the next clock edge.
- R2: A status bit, once set, stays set until a soft reset or a hardware reset. No write to any register clears it.
- R3: irq_o is high exactly when some status bit is set in both the enable mask and the signal-enable mask. It follows the registered state with no extra delay.
- R4: Writes with wr_sel_i = 0 load the enable mask and wr_sel_i = 1 load the signal-enable mask, both from wr_data_i[11:0]. They take effect at the next clock edge, and only the nine implemented bit positions are stored. Writing zero to the enable mask drops irq_o in the following cycle.
- R5: A write with wr_sel_i = 2 loads the tx threshold from wr_data_i[12:8] and the rx threshold from wr_data_i[4:0]. thr_o reads both fields back at the same positions, and both fields reset to 1.
- R6: A write with wr_sel_i = 3 and wr_data_i[16] = 1 starts a soft reset. busy_o is high for RST_CYCLES cycles, beginning at the next edge. While busy_o is high, the status word is held at 0, irq_o is low, events are ignored, the thresholds read 1 and threshold writes are ignored. The masks keep their values.
- R7: In the cycle after busy_o falls, FIFO conditions that still hold are caught again, and irq_o rises if the retained masks select them.
- R8: Under hardware reset the status word, both masks and busy_o are 0, irq_o is low and thr_o reads 0x0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy |
| rx_level_i | input | LVL_W | Receive FIFO occupancy |
| desc_done_i | input | 1 | Descriptor finished pulse |
| pkt_done_i | input | 1 | Packet finished pulse |
| dma_err_i | input | 1 | DMA error pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 enable, 1 signal-enable, 2 thresholds, 3 control |
| wr_data_i | input | 17 | Write data |
| stat_o | output | 12 | Sticky status word |
| irq_o | output | 1 | Level-high interrupt line |
| busy_o | output | 1 | Soft reset in progress |
| thr_o | output | 13 | Threshold readback |

## Verification
The checker takes the FIFO levels to stay between 0 and FIFO_DEPTH. It also takes no new soft reset request to arrive while one is still running. Its run-length bound on busy_o depends on that second point. The stimulus drives levels only inside that range and issues each soft reset only after busy_o has been seen low. Event pulses are placed both inside and outside the reset window, so both the ignore rule and the sticky rule are exercised.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
    localparam int STAT_W     = 12;
    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_FULL  = 1;
    localparam int B_TX_THR   = 2;
    localparam int B_RX_EMPTY = 3;
    localparam int B_RX_FULL  = 4;
    localparam int B_RX_THR   = 5;
    localparam int B_DESC     = 9;
    localparam int B_PKT      = 10;
    localparam int B_DMA_ERR  = 11;
    localparam logic [STAT_W-1:0] STAT_IMPL = 12'hE3F;

    localparam int THR_W      = 5;
    localparam int TX_THR_LSB = 8;
    localparam int RX_THR_LSB = 0;
    localparam int THR_OUT_W  = TX_THR_LSB + THR_W;
    localparam logic [THR_W-1:0] THR_INIT = 5'd1;

    localparam int SRST_BIT   = 16;
    localparam int WDATA_W    = SRST_BIT + 1;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_SIGEN  = 2'd1,
        SEL_THRESH = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] en;
        logic [STAT_W-1:0] sig;
        logic [THR_W-1:0]  tx_thr;
        logic [THR_W-1:0]  rx_thr;
    } cfg_t;
endpackage

// File: rtl/flash_irq_level_flags.sv
module flash_irq_level_flags
    import flash_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 5,
    parameter bit FILL_SIDE  = 1'b0   // 0: drain side (tx), 1: fill side (rx)
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             empty_o,
    output logic             full_o,
    output logic             thr_hit_o
);
    assign empty_o = (level_i == '0);
    assign full_o  = (int'(level_i) == FIFO_DEPTH);

    generate
        if (FILL_SIDE) begin : g_fill
            assign thr_hit_o = (int'(level_i) >= int'(thr_i));
        end else begin : g_drain
            assign thr_hit_o = (int'(level_i) <= int'(thr_i));
        end
    endgenerate
endmodule

// File: rtl/flash_irq_sreset.sv
module flash_irq_sreset #(
    parameter  int RST_CYCLES = 4,
    localparam int CNT_W      = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(RST_CYCLES - 1);
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
endmodule

// File: rtl/flash_irq_cfg.sv
module flash_irq_cfg
    import flash_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  reg_sel_e           wr_sel_i,
    input  logic [WDATA_W-1:0] wr_data_i,
    input  logic               hold_i,
    output cfg_t               cfg_o
);
    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_en_i && wr_sel_i == SEL_ENABLE) begin
            c_d.en = wr_data_i[STAT_W-1:0] & STAT_IMPL;
        end
        if (wr_en_i && wr_sel_i == SEL_SIGEN) begin
            c_d.sig = wr_data_i[STAT_W-1:0] & STAT_IMPL;
        end
        if (hold_i) begin
            c_d.tx_thr = THR_INIT;
            c_d.rx_thr = THR_INIT;
        end else if (wr_en_i && wr_sel_i == SEL_THRESH) begin
            c_d.tx_thr = wr_data_i[TX_THR_LSB +: THR_W];
            c_d.rx_thr = wr_data_i[RX_THR_LSB +: THR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.tx_thr <= THR_INIT;
            c_q.rx_thr <= THR_INIT;
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg_o = c_q;
endmodule

// File: rtl/flash_irq_sticky.sv
module flash_irq_sticky
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] event_i,
    input  logic              clear_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        if (clear_i) begin
            stat_d = '0;
        end else begin
            stat_d = stat_q | (event_i & STAT_IMPL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
    import flash_irq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    parameter  int RST_CYCLES = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LVL_W-1:0]     tx_level_i,
    input  logic [LVL_W-1:0]     rx_level_i,
    input  logic                 desc_done_i,
    input  logic                 pkt_done_i,
    input  logic                 dma_err_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic [WDATA_W-1:0]   wr_data_i,
    output logic [STAT_W-1:0]    stat_o,
    output logic                 irq_o,
    output logic                 busy_o,
    output logic [THR_OUT_W-1:0] thr_o
);
    reg_sel_e          sel;
    cfg_t              cfg;
    logic              srst_start;
    logic              srst_busy;
    logic              hold;
    logic [STAT_W-1:0] events;
    logic [STAT_W-1:0] stat;
    logic              tx_empty, tx_full, tx_thr_hit;
    logic              rx_empty, rx_full, rx_thr_hit;

    assign sel        = reg_sel_e'(wr_sel_i);
    assign srst_start = wr_en_i && (sel == SEL_CTRL) && wr_data_i[SRST_BIT];
    assign hold       = srst_start || srst_busy;

    flash_irq_level_flags #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W),
        .FILL_SIDE  (1'b0)
    ) u_tx_flags (
        .level_i   (tx_level_i),
        .thr_i     (cfg.tx_thr),
        .empty_o   (tx_empty),
        .full_o    (tx_full),
        .thr_hit_o (tx_thr_hit)
    );

    flash_irq_level_flags #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W),
        .FILL_SIDE  (1'b1)
    ) u_rx_flags (
        .level_i   (rx_level_i),
        .thr_i     (cfg.rx_thr),
        .empty_o   (rx_empty),
        .full_o    (rx_full),
        .thr_hit_o (rx_thr_hit)
    );

    always_comb begin
        events             = '0;
        events[B_TX_EMPTY] = tx_empty;
        events[B_TX_FULL]  = tx_full;
        events[B_TX_THR]   = tx_thr_hit;
        events[B_RX_EMPTY] = rx_empty;
        events[B_RX_FULL]  = rx_full;
        events[B_RX_THR]   = rx_thr_hit;
        events[B_DESC]     = desc_done_i;
        events[B_PKT]      = pkt_done_i;
        events[B_DMA_ERR]  = dma_err_i;
    end

    flash_irq_sreset #(
        .RST_CYCLES (RST_CYCLES)
    ) u_sreset (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (srst_start),
        .busy_o  (srst_busy)
    );

    flash_irq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (sel),
        .wr_data_i (wr_data_i),
        .hold_i    (hold),
        .cfg_o     (cfg)
    );

    flash_irq_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (events),
        .clear_i (hold),
        .stat_o  (stat)
    );

    always_comb begin
        thr_o                          = '0;
        thr_o[TX_THR_LSB +: THR_W]     = cfg.tx_thr;
        thr_o[RX_THR_LSB +: THR_W]     = cfg.rx_thr;
    end

    assign stat_o = stat;
    assign irq_o  = |(stat & cfg.en & cfg.sig);
    assign busy_o = srst_busy;
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk
    import flash_irq_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [1:0]           wr_sel_i,
    input logic [STAT_W-1:0]    wr_mask,
    input logic [STAT_W-1:0]    stat_o,
    input logic                 irq_o,
    input logic                 busy_o,
    input logic [THR_OUT_W-1:0] thr_o
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy_o) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o & ~STAT_IMPL) == '0);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_o) & ~stat_o)) |-> busy_o);

    // R3
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_o != '0));

    // R4
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_ENABLE && wr_mask == '0) |=> !irq_o);

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (stat_o == '0 && !irq_o));

    // R6
    busy_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (thr_o[TX_THR_LSB +: THR_W] == THR_INIT &&
                    thr_o[RX_THR_LSB +: THR_W] == THR_INIT));

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len < RST_CYCLES));
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_mask  (wr_data_i[11:0]),
    .stat_o   (stat_o),
    .irq_o    (irq_o),
    .busy_o   (busy_o),
    .thr_o    (thr_o)
);

// File: tb/test_flash_irq_ctrl.sv
module test_flash_irq_ctrl;
    localparam int DEPTH = 16;
    localparam int NRST  = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic [LW-1:0] rx_level = '0;
    logic          desc_done = 1'b0, pkt_done = 1'b0, dma_err = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [16:0]   wr_data = '0;
    logic [11:0]   stat;
    logic          irq, busy;
    logic [12:0]   thr;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    flash_irq_ctrl #(.FIFO_DEPTH(DEPTH), .RST_CYCLES(NRST)) i_flash_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .tx_level_i(tx_level), .rx_level_i(rx_level),
        .desc_done_i(desc_done), .pkt_done_i(pkt_done), .dma_err_i(dma_err),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .stat_o(stat), .irq_o(irq), .busy_o(busy), .thr_o(thr)
    );

    always #4 clk = ~clk;

    // behavioural reference
    logic [11:0] m_stat, m_en, m_sig;
    int          m_txthr, m_rxthr, m_cnt;
    bit          m_busy;

    always @(posedge clk) begin
        logic [11:0] ev;
        bit          start, clr;
        started = 1;
        if (!rst_n) begin
            m_stat = '0; m_en = '0; m_sig = '0;
            m_txthr = 1; m_rxthr = 1; m_busy = 0; m_cnt = 0;
        end else begin
            ev = '0;
            ev[0]  = (tx_level == 0);
            ev[1]  = (int'(tx_level) == DEPTH);
            ev[2]  = (int'(tx_level) <= m_txthr);
            ev[3]  = (rx_level == 0);
            ev[4]  = (int'(rx_level) == DEPTH);
            ev[5]  = (int'(rx_level) >= m_rxthr);
            ev[9]  = desc_done;
            ev[10] = pkt_done;
            ev[11] = dma_err;
            start = wr_en && wr_sel == 2'd3 && wr_data[16];
            clr   = start || m_busy;
            m_stat = clr ? 12'h000 : (m_stat | ev);
            if (wr_en && wr_sel == 2'd0) m_en  = wr_data[11:0] & 12'hE3F;
            if (wr_en && wr_sel == 2'd1) m_sig = wr_data[11:0] & 12'hE3F;
            if (clr) begin
                m_txthr = 1; m_rxthr = 1;
            end else if (wr_en && wr_sel == 2'd2) begin
                m_txthr = int'(wr_data[12:8]); m_rxthr = int'(wr_data[4:0]);
            end
            if (start) begin
                m_busy = 1; m_cnt = NRST - 1;
            end else if (m_busy) begin
                if (m_cnt == 0) m_busy = 0; else m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (started && !done) begin
            check("R1/R2 status", int'(stat), int'(m_stat));
            check("R3 irq", int'(irq), int'(|(m_stat & m_en & m_sig)));
            check("R6 busy", int'(busy), int'(m_busy));
            check("R5 thr", int'(thr), (m_txthr << 8) | m_rxthr);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [16:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        cyc(3);
        // R8 reset state
        check("R8 reset status", int'(stat), 0);
        check("R8 reset irq", int'(irq), 0);
        check("R8 reset thr", int'(thr), 'h101);
        rst_n = 1'b1;
        cyc(1);
        // R1 empty FIFOs: tx empty, tx threshold, rx empty
        check("R1 empty levels", int'(stat), 'h00D);

        wr(2'd0, 17'h0FFF);
        check("R4 enable alone no irq", int'(irq), 0);
        wr(2'd1, 17'h0001);
        check("R3 irq via tx empty", int'(irq), 1);
        wr(2'd0, 17'h0000);
        check("R4 masking quiets line", int'(irq), 0);
        check("R2 status kept after mask", int'(stat), 'h00D);

        wr(2'd0, 17'h0200);
        wr(2'd1, 17'h0200);
        check("R3 desc not yet seen", int'(irq), 0);
        desc_done = 1'b1; cyc(1); desc_done = 1'b0;
        check("R1 desc done bit", int'(stat), 'h20D);
        check("R3 irq on desc done", int'(irq), 1);

        tx_level = 5'd16; rx_level = 5'd16; cyc(1);
        check("R1 full levels", int'(stat), 'h23F);
        tx_level = 5'd7; rx_level = 5'd0; cyc(2);
        check("R2 sticky after levels move", int'(stat), 'h23F);

        wr(2'd2, 17'h00307);
        check("R5 threshold readback", int'(thr), 'h307);
        pkt_done = 1'b1; dma_err = 1'b1; cyc(1); pkt_done = 1'b0; dma_err = 1'b0;
        check("R1 pkt and dma error", int'(stat), 'hE3F);
        wr(2'd1, 17'h1FFFF);
        check("R4 reserved bits dropped", int'(stat & 12'h1C0), 0);

        // soft reset with rx threshold condition kept alive
        wr(2'd0, 17'h0020);
        wr(2'd1, 17'h0020);
        tx_level = 5'd8; rx_level = 5'd4;
        wr(2'd3, 17'h10000);
        check("R6 busy starts", int'(busy), 1);
        check("R6 status cleared", int'(stat), 0);
        check("R6 thr restored", int'(thr), 'h101);
        desc_done = 1'b1;
        wr(2'd2, 17'h00808);
        desc_done = 1'b0;
        cyc(2);
        check("R6 still busy", int'(busy), 1);
        check("R6 event ignored", int'(stat), 0);
        cyc(1);
        check("R6 busy ends", int'(busy), 0);
        check("R6 thr write ignored", int'(thr), 'h101);
        cyc(1);
        check("R7 relatch rx threshold", int'(stat), 'h020);
        check("R7 irq from retained masks", int'(irq), 1);

        wr(2'd2, 17'h00806);
        cyc(1);
        check("R5 tx threshold reached", int'(stat), 'h024);

        tx_level = 5'd0; rx_level = 5'd0;
        cyc(20);
        finish_run();
    end
endmodule